// File: doc/BRIEF.md
# Light-Load Phase Shedding Sequencer

This block decides whether one power-stage phase is allowed to switch. An active-low power-state request arrives asynchronously. It is brought onto the fast system clock through a synchroniser chain and then treated as a clean level. When the request goes low, the phase does not stop at once. It keeps switching while a fixed number of phase-token arrivals are counted, and only then does it drop its enable. This gives the rest of the converter time to absorb the load. When the request returns high, the phase is re-enabled within the synchroniser latency plus one clock.

On re-enable the block raises a "high-side first" flag towards the gate arbiter. The flag holds until the arbiter acknowledges that a high-side turn-on has occurred, so the phase always resumes with a high-side pulse and never with a low-side one. While the phase is shed, a status output reports it. The gate arbiter uses the low enable to hold both gate outputs low and to inhibit its ramp reset. The current-sense path is not gated by this block.

Top module: `phase_shed_seq`

## Requirements
- R1: After reset, `phase_en` is 1, `hs_first` is 0 and `shed_stat` is 0.
- R2: While the synchronised request is low and fewer than SHED_TOKENS token strobes have been counted, `phase_en` stays 1.
- R3: On the clock edge that samples the SHED_TOKENS-th token strobe while the synchronised request is low, the phase is shed: from that edge `phase_en` is 0 and `shed_stat` is 1.
- R4: If the request returns high before the count completes, the count clears to zero, and a later low request needs a full SHED_TOKENS strobes again.
- R5: Once `lp_req_n` is high, a shed phase has `phase_en` at 1 after at most SYNC_STAGES+1 rising clock edges.
- R6: Leaving the shed state sets `hs_first` to 1. It stays 1 until `hs_ack` is sampled high while the phase is enabled, and the edge that samples that `hs_ack` clears it to 0.
- R7: Token strobes that arrive while the synchronised request is high are not counted.
- R8: `shed_stat` is always the inverse of `phase_en`.
- R9: `hs_ack` while no high-side-first flag is pending leaves `hs_first` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_req_n | input | 1 | Power-state request, low = low-power state, asynchronous |
| tok_stb | input | 1 | One-cycle strobe per phase-token arrival, synchronous to clk |
| hs_ack | input | 1 | Gate arbiter reports a high-side turn-on |
| phase_en | output | 1 | Phase may switch |
| hs_first | output | 1 | Next drive action must be a high-side turn-on |
| shed_stat | output | 1 | Phase is shed |

## Verification
The bench builds the block with SHED_TOKENS = 8 and SYNC_STAGES = 2. These small values let it sweep every token count from 0 to 10 within a single low-request window. It also times the wake-up edge by edge against the synchroniser depth. Abort patterns cover a request that returns high after every partial count. This exposes any count that survives an abort. The same approach checks that tokens arriving during normal running are never banked.

// File: rtl/shed_pkg.sv
package shed_pkg;
  typedef enum logic [1:0] {
    SQ_RUN  = 2'd0,
    SQ_ARM  = 2'd1,
    SQ_SHED = 2'd2
  } seq_state_t;
endpackage

// File: rtl/shed_sync.sv
module shed_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= RST_VAL;
        else        chain[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= RST_VAL;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/shed_tok_cnt.sv
module shed_tok_cnt #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic done
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  assign done = inc && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (done)   cnt <= '0;
    else if (inc)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/shed_hs_flag.sv
module shed_hs_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/phase_shed_seq.sv
module phase_shed_seq
  import shed_pkg::*;
#(
  parameter int SHED_TOKENS = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lp_req_n,
  input  logic tok_stb,
  input  logic hs_ack,
  output logic phase_en,
  output logic hs_first,
  output logic shed_stat
);
  seq_state_t st, nxt;
  logic req_s;
  logic cnt_clr, cnt_inc, cnt_done;
  logic wake;

  shed_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(lp_req_n), .q(req_s)
  );

  shed_tok_cnt #(.LIMIT(SHED_TOKENS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .done(cnt_done)
  );

  always_comb begin
    nxt     = st;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    wake    = 1'b0;
    unique case (st)
      SQ_RUN: begin
        cnt_clr = 1'b1;
        if (!req_s) nxt = SQ_ARM;
      end
      SQ_ARM: begin
        if (req_s) begin
          nxt     = SQ_RUN;
          cnt_clr = 1'b1;
        end else begin
          cnt_inc = tok_stb;
          if (cnt_done) nxt = SQ_SHED;
        end
      end
      SQ_SHED: begin
        cnt_clr = 1'b1;
        if (req_s) begin
          nxt  = SQ_RUN;
          wake = 1'b1;
        end
      end
      default: begin
        nxt     = SQ_RUN;
        cnt_clr = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= SQ_RUN;
    else        st <= nxt;
  end

  shed_hs_flag u_hs (
    .clk(clk), .rst_n(rst_n),
    .set(wake), .clr(hs_ack && (st != SQ_SHED)),
    .flag(hs_first)
  );

  assign shed_stat = (st == SQ_SHED);
  assign phase_en  = !shed_stat;
endmodule

// File: rtl/phase_shed_chk.sv
module phase_shed_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic lp_req_n,
  input logic tok_stb,
  input logic hs_ack,
  input logic phase_en,
  input logic hs_first,
  input logic shed_stat
);
  logic [7:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_run <= '0;
    else if (!lp_req_n) hi_run <= '0;
    else if (hi_run != 8'hFF) hi_run <= hi_run + 1'b1;
  end

  // R8
  excl_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shed_stat != phase_en);

  // R3
  shed_on_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shed_stat) |-> $past(tok_stb));

  // R5
  wake_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(hi_run) >= SYNC_STAGES + 1) |-> phase_en);

  // R6
  hs_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shed_stat) |-> hs_first);

  // R6
  hs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_first && !hs_ack) |=> hs_first);
endmodule

bind phase_shed_seq phase_shed_chk #(.SYNC_STAGES(SYNC_STAGES)) u_shed_chk (
  .clk(clk), .rst_n(rst_n), .lp_req_n(lp_req_n), .tok_stb(tok_stb),
  .hs_ack(hs_ack), .phase_en(phase_en), .hs_first(hs_first),
  .shed_stat(shed_stat)
);

// File: tb/test_phase_shed_seq.sv
module test_phase_shed_seq;
  localparam int NTOK  = 8;
  localparam int NSYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lp_req_n = 1'b1;
  logic tok_stb = 1'b0;
  logic hs_ack = 1'b0;
  logic phase_en, hs_first, shed_stat;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  phase_shed_seq #(.SHED_TOKENS(NTOK), .SYNC_STAGES(NSYNC)) i_phase_shed_seq (
    .clk(clk), .rst_n(rst_n), .lp_req_n(lp_req_n), .tok_stb(tok_stb),
    .hs_ack(hs_ack), .phase_en(phase_en), .hs_first(hs_first),
    .shed_stat(shed_stat)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tok(input int n);
    for (int i = 0; i < n; i++) begin
      tok_stb = 1'b1; cyc(1);
      tok_stb = 1'b0; cyc(1);
    end
  endtask

  task automatic ack();
    hs_ack = 1'b1; cyc(1);
    hs_ack = 1'b0; cyc(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog all-reqs actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(3);
    // R1 reset state
    chk("R1", "phase_en", phase_en, 1'b1);
    chk("R1", "hs_first", hs_first, 1'b0);
    chk("R1", "shed_stat", shed_stat, 1'b0);
    rst_n = 1'b1;
    cyc(2);

    // R9 ack with nothing pending
    ack();
    chk("R9", "hs_first", hs_first, 1'b0);

    // Sweep token counts within one low window
    for (int n = 0; n <= 10; n++) begin
      lp_req_n = 1'b0; cyc(NSYNC + 2);
      tok(n);
      // R2 below limit, R3 at/after limit
      chk((n < NTOK) ? "R2" : "R3", "phase_en", phase_en, (n < NTOK));
      chk("R8", "shed_stat", shed_stat, !(n < NTOK));
      lp_req_n = 1'b1;
      if (n >= NTOK) begin
        cyc(NSYNC);
        chk("R5", "phase_en early", phase_en, 1'b0);
        cyc(1);
        chk("R5", "phase_en", phase_en, 1'b1);
        chk("R6", "hs_first set", hs_first, 1'b1);
        cyc(5);
        chk("R6", "hs_first held", hs_first, 1'b1);
        ack();
        chk("R6", "hs_first cleared", hs_first, 1'b0);
      end else begin
        cyc(NSYNC + 2);
        chk("R6", "hs_first idle", hs_first, 1'b0);
      end
    end

    // R4 abort after every partial count
    for (int k = 1; k < NTOK; k++) begin
      lp_req_n = 1'b0; cyc(NSYNC + 2);
      tok(k);
      lp_req_n = 1'b1; cyc(NSYNC + 2);
      lp_req_n = 1'b0; cyc(NSYNC + 2);
      tok(NTOK - 1);
      chk("R4", "phase_en after abort", phase_en, 1'b1);
      tok(1);
      chk("R4", "shed after full count", shed_stat, 1'b1);
      lp_req_n = 1'b1; cyc(NSYNC + 2);
      ack();
    end

    // R7 tokens while running are not banked
    tok(3 * NTOK);
    lp_req_n = 1'b0; cyc(NSYNC + 2);
    tok(NTOK - 1);
    chk("R7", "phase_en", phase_en, 1'b1);
    tok(1);
    chk("R7", "shed_stat", shed_stat, 1'b1);
    lp_req_n = 1'b1; cyc(NSYNC + 2);
    chk("R5", "phase_en", phase_en, 1'b1);
    ack();
    chk("R6", "hs_first", hs_first, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule